// File: doc/BRIEF.md
# CAN Controller Mode and Bus-State Register Block

This block is the register shell that sits beside a CAN protocol engine. Software programs one combined control and bit-timing word, moves the controller into and out of configuration mode through a request/acknowledge handshake, and reads the transmit and receive error states and the error counters that the engine reports. The engine itself, including error counting, is outside the block; its state and counter outputs arrive here as inputs.

Mode changes are not immediate. A request bit written by software is echoed in an acknowledge bit after a fixed, parameterised number of clocks, and the configuration fields that alter bus timing or bus behaviour only accept new values while configuration mode is acknowledged. Writes outside that window leave those fields untouched while the request bits still update. Any change of either 2-bit error state raises a sticky flag that software clears by writing one, and the flag can drive an interrupt line. Requesting configuration mode does not clear the reported error states or the flag.

The register map has four word addresses: 0 control/timing, 1 interrupt enable, 2 status, 3 error counters.

Top module: `cms_mode_state_regs`

## Requirements
- R1: After reset the control word reads 0x0000_8000, the interrupt-enable word and the status flag read 0, and irq is low.
- R2: Control bit 0 is the configuration request; control bit 8 is its acknowledge, which takes the request's value exactly ACK_LAT clocks after the clock edge that wrote the request, for both entry and exit.
- R3: Control bit 1 is the sleep request and control bit 9 its acknowledge, following with the same ACK_LAT-clock handshake.
- R4: Control bits 31:16 (timing), 13 (loopback) and 12 (listen-only) take the written value only when bit 8 is 1 at the writing edge; otherwise they keep their value while bits 1:0 still update.
- R5: Control bit 15 always reads 1 and ignores writes.
- R6: Status bits 19:18 show the transmit error state and 21:20 the receive error state, encoded 0 active, 1 warning, 2 passive, 3 bus off.
- R7: Status bit 22 sets at the clock edge where either error-state input differs from its value at the previous edge.
- R8: Writing status with bit 22 = 1 clears the flag, bit 22 = 0 leaves it; a state change at the same edge wins over the clear.
- R9: Interrupt-enable bit 6 (address 1, other bits read 0) gates the flag onto irq: irq = flag AND enable.
- R10: Entering configuration mode leaves the status state fields and the flag as they were.
- R11: Address 3 reads the receive error count in bits 7:0 and the transmit error count in bits 23:16, other bits 0.
- R12: The cfg outputs carry the stored fields: cfg_brp = bits 21:16, cfg_sjw = 23:22, cfg_tseg1 = 27:24, cfg_tseg2 = 30:28, cfg_triple = 31, cfg_listen = 12, cfg_loopback = 13, cfg_init = bit 8, cfg_sleep = bit 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| eng_tx_state | input | 2 | Transmit error state from the engine |
| eng_rx_state | input | 2 | Receive error state from the engine |
| eng_rx_errcnt | input | 8 | Receive error count from the engine |
| eng_tx_errcnt | input | 8 | Transmit error count from the engine |
| irq | output | 1 | State-change interrupt |
| cfg_init | output | 1 | Configuration mode acknowledged |
| cfg_sleep | output | 1 | Sleep mode acknowledged |
| cfg_listen | output | 1 | Listen-only enable |
| cfg_loopback | output | 1 | Loopback enable |
| cfg_brp | output | 6 | Prescaler minus one |
| cfg_sjw | output | 2 | Jump width minus one |
| cfg_tseg1 | output | 4 | First segment minus one |
| cfg_tseg2 | output | 3 | Second segment minus one |
| cfg_triple | output | 1 | Triple sampling |

## Verification
The assertions take for granted that the engine's state inputs are at the active encoding (zero) while reset is held, so the first compare after reset sees no spurious change, and that the engine holds its inputs stable across each sampling edge. The bench drives every input on the falling edge and keeps the state inputs at zero throughout reset; its random phase changes the states and fires clear writes in arbitrary combinations, including clears on the same edge as a change, while the directed part walks the handshake and the write-gating window.

// File: rtl/cms_pkg.sv
`timescale 1ns/1ps
package cms_pkg;
  localparam int unsigned DW      = 32;
  localparam int unsigned AW      = 2;
  localparam int unsigned ST_W    = 2;
  localparam int unsigned CNT_W   = 8;
  localparam int unsigned TIM_W   = 16;

  localparam logic [AW-1:0] A_CTRL = 2'd0;
  localparam logic [AW-1:0] A_IEN  = 2'd1;
  localparam logic [AW-1:0] A_STAT = 2'd2;
  localparam logic [AW-1:0] A_ECNT = 2'd3;

  localparam int unsigned B_INIT_REQ = 0;
  localparam int unsigned B_SLP_REQ  = 1;
  localparam int unsigned B_LISTEN   = 12;
  localparam int unsigned B_LOOPB    = 13;
  localparam int unsigned B_FLAG     = 22;
  localparam int unsigned B_IEN_SC   = 6;

  typedef enum logic [ST_W-1:0] {
    ES_ACTIVE  = 2'd0,
    ES_WARN    = 2'd1,
    ES_PASSIVE = 2'd2,
    ES_BUSOFF  = 2'd3
  } err_state_e;

  // Laid out so that the packed struct lands on control bits 31:16.
  typedef struct packed {
    logic       triple;
    logic [2:0] tseg2;
    logic [3:0] tseg1;
    logic [1:0] sjw;
    logic [5:0] brp;
  } timing_t;

  function automatic logic [DW-1:0] ctrl_word(input timing_t t, input logic loopb,
                                              input logic listen, input logic slp_ack,
                                              input logic init_ack, input logic slp_req,
                                              input logic init_req);
    logic [DW-1:0] w;
    w        = '0;
    w[31:16] = t;
    w[15]    = 1'b1;
    w[13]    = loopb;
    w[12]    = listen;
    w[9]     = slp_ack;
    w[8]     = init_ack;
    w[1]     = slp_req;
    w[0]     = init_req;
    return w;
  endfunction

  function automatic logic [DW-1:0] stat_word(input logic flag,
                                              input logic [ST_W-1:0] rx,
                                              input logic [ST_W-1:0] tx);
    logic [DW-1:0] w;
    w         = '0;
    w[B_FLAG] = flag;
    w[21:20]  = rx;
    w[19:18]  = tx;
    return w;
  endfunction

  function automatic logic [DW-1:0] ecnt_word(input logic [CNT_W-1:0] txc,
                                              input logic [CNT_W-1:0] rxc);
    logic [DW-1:0] w;
    w        = '0;
    w[23:16] = txc;
    w[7:0]   = rxc;
    return w;
  endfunction
endpackage

// File: rtl/cms_handshake.sv
`timescale 1ns/1ps
module cms_handshake #(
  parameter int unsigned LAT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic ack
);
  localparam int unsigned CW = (LAT < 2) ? 1 : $clog2(LAT + 1);
  localparam logic [CW-1:0] LAST = CW'(LAT - 1);

  logic [CW-1:0] wait_cnt;
  logic          pending;

  assign pending = (req != ack);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_cnt <= '0;
      ack      <= 1'b0;
    end else if (!pending) begin
      wait_cnt <= '0;
    end else if (wait_cnt == LAST) begin
      wait_cnt <= '0;
      ack      <= req;
    end else begin
      wait_cnt <= wait_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/cms_state_watch.sv
`timescale 1ns/1ps
module cms_state_watch
  import cms_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ST_W-1:0] tx_state,
  input  logic [ST_W-1:0] rx_state,
  input  logic            clr,
  output logic            change,
  output logic            flag
);
  logic [ST_W-1:0] tx_prev, rx_prev;

  assign change = (tx_state != tx_prev) || (rx_state != rx_prev);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_prev <= ES_ACTIVE;
      rx_prev <= ES_ACTIVE;
      flag    <= 1'b0;
    end else begin
      tx_prev <= tx_state;
      rx_prev <= rx_state;
      if (change)   flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/cms_ctrl_reg.sv
`timescale 1ns/1ps
module cms_ctrl_reg
  import cms_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [DW-1:0] wdata,
  input  logic       init_ack,
  output logic       init_req,
  output logic       slp_req,
  output logic       listen,
  output logic       loopb,
  output timing_t    timing,
  output logic       cfg_open
);
  assign cfg_open = wr && init_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_req <= 1'b0;
      slp_req  <= 1'b0;
      listen   <= 1'b0;
      loopb    <= 1'b0;
      timing   <= '0;
    end else begin
      if (wr) begin
        init_req <= wdata[B_INIT_REQ];
        slp_req  <= wdata[B_SLP_REQ];
      end
      if (cfg_open) begin
        listen <= wdata[B_LISTEN];
        loopb  <= wdata[B_LOOPB];
        timing <= wdata[31:16];
      end
    end
  end
endmodule

// File: rtl/cms_mode_state_regs.sv
`timescale 1ns/1ps
module cms_mode_state_regs
  import cms_pkg::*;
#(
  parameter int unsigned ACK_LAT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic [ST_W-1:0]  eng_tx_state,
  input  logic [ST_W-1:0]  eng_rx_state,
  input  logic [CNT_W-1:0] eng_rx_errcnt,
  input  logic [CNT_W-1:0] eng_tx_errcnt,
  output logic             irq,
  output logic             cfg_init,
  output logic             cfg_sleep,
  output logic             cfg_listen,
  output logic             cfg_loopback,
  output logic [5:0]       cfg_brp,
  output logic [1:0]       cfg_sjw,
  output logic [3:0]       cfg_tseg1,
  output logic [2:0]       cfg_tseg2,
  output logic             cfg_triple
);
  localparam int unsigned NHS = 2;

  logic ctrl_wr, ien_wr, stat_clr;
  logic init_req, slp_req, init_ack, slp_ack;
  logic listen_q, loopb_q, cfg_open;
  logic state_chg, sc_flag, ien_q;
  timing_t timing_q;
  logic [NHS-1:0] hs_req, hs_ack;
  logic unused_wbits;

  assign ctrl_wr  = reg_wr && (reg_addr == A_CTRL);
  assign ien_wr   = reg_wr && (reg_addr == A_IEN);
  assign stat_clr = reg_wr && (reg_addr == A_STAT) && reg_wdata[B_FLAG];
  assign unused_wbits = ^{reg_wdata[15:14], reg_wdata[11:7], reg_wdata[5:2]};

  cms_ctrl_reg u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (ctrl_wr),
    .wdata    (reg_wdata),
    .init_ack (init_ack),
    .init_req (init_req),
    .slp_req  (slp_req),
    .listen   (listen_q),
    .loopb    (loopb_q),
    .timing   (timing_q),
    .cfg_open (cfg_open)
  );

  assign hs_req = {slp_req, init_req};

  for (genvar g = 0; g < NHS; g++) begin : g_hs
    cms_handshake #(.LAT(ACK_LAT)) u_hs (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (hs_req[g]),
      .ack   (hs_ack[g])
    );
  end

  assign init_ack = hs_ack[0];
  assign slp_ack  = hs_ack[1];

  cms_state_watch u_watch (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_state (eng_tx_state),
    .rx_state (eng_rx_state),
    .clr      (stat_clr),
    .change   (state_chg),
    .flag     (sc_flag)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      ien_q <= 1'b0;
    else if (ien_wr) ien_q <= reg_wdata[B_IEN_SC];
  end

  assign irq = sc_flag && ien_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: reg_rdata = ctrl_word(timing_q, loopb_q, listen_q, slp_ack, init_ack,
                                    slp_req, init_req);
      A_IEN:  reg_rdata[B_IEN_SC] = ien_q;
      A_STAT: reg_rdata = stat_word(sc_flag, eng_rx_state, eng_tx_state);
      default: reg_rdata = ecnt_word(eng_tx_errcnt, eng_rx_errcnt);
    endcase
  end

  assign cfg_init     = init_ack;
  assign cfg_sleep    = slp_ack;
  assign cfg_listen   = listen_q;
  assign cfg_loopback = loopb_q;
  assign cfg_brp      = timing_q.brp;
  assign cfg_sjw      = timing_q.sjw;
  assign cfg_tseg1    = timing_q.tseg1;
  assign cfg_tseg2    = timing_q.tseg2;
  assign cfg_triple   = timing_q.triple;
endmodule

// File: rtl/cms_checker.sv
`timescale 1ns/1ps
module cms_checker
  import cms_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] reg_addr,
  input logic          en_bit,
  input logic          clr_wr,
  input logic          irq,
  input logic          init_req,
  input logic          init_ack,
  input logic          slp_req,
  input logic          slp_ack,
  input logic [TIM_W-1:0] timing,
  input logic          listen,
  input logic          loopb,
  input logic          state_chg,
  input logic          sc_flag
);
  // R2
  init_ack_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (init_ack != $past(init_ack)) |-> (init_ack == $past(init_req)));

  // R3
  slp_ack_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slp_ack != $past(slp_ack)) |-> (slp_ack == $past(slp_req)));

  // R4
  timing_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(init_ack) |-> ($stable(timing) && $stable(listen) && $stable(loopb)));

  // R5
  enabled_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_CTRL) |-> en_bit);

  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_chg |=> sc_flag);

  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sc_flag) |-> $past(clr_wr));

  // R9
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> sc_flag);
endmodule

bind cms_mode_state_regs cms_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_addr  (reg_addr),
  .en_bit    (reg_rdata[15]),
  .clr_wr    (stat_clr),
  .irq       (irq),
  .init_req  (init_req),
  .init_ack  (init_ack),
  .slp_req   (slp_req),
  .slp_ack   (slp_ack),
  .timing    (timing_q),
  .listen    (listen_q),
  .loopb     (loopb_q),
  .state_chg (state_chg),
  .sc_flag   (sc_flag)
);

// File: tb/cms_mode_state_regs_tb.sv
`timescale 1ns/1ps
module cms_mode_state_regs_tb;
  localparam int LAT = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [1:0]  eng_tx_state = 2'd0, eng_rx_state = 2'd0;
  logic [7:0]  eng_rx_errcnt = 8'd0, eng_tx_errcnt = 8'd0;
  logic        irq, cfg_init, cfg_sleep, cfg_listen, cfg_loopback, cfg_triple;
  logic [5:0]  cfg_brp;
  logic [1:0]  cfg_sjw;
  logic [3:0]  cfg_tseg1;
  logic [2:0]  cfg_tseg2;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cms_mode_state_regs #(.ACK_LAT(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .eng_tx_state(eng_tx_state), .eng_rx_state(eng_rx_state),
    .eng_rx_errcnt(eng_rx_errcnt), .eng_tx_errcnt(eng_tx_errcnt),
    .irq(irq), .cfg_init(cfg_init), .cfg_sleep(cfg_sleep),
    .cfg_listen(cfg_listen), .cfg_loopback(cfg_loopback),
    .cfg_brp(cfg_brp), .cfg_sjw(cfg_sjw), .cfg_tseg1(cfg_tseg1),
    .cfg_tseg2(cfg_tseg2), .cfg_triple(cfg_triple)
  );

  // Expected words, built from the requirement bit positions.
  function automatic logic [31:0] exp_stat(input logic f, input logic [1:0] rx,
                                           input logic [1:0] tx);
    return (32'(f) << 22) | (32'(rx) << 20) | (32'(tx) << 18);
  endfunction

  function automatic logic [31:0] exp_ecnt(input logic [7:0] rx, input logic [7:0] tx);
    return {8'h00, tx, 8'h00, rx};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected done");
      summary();
    end
  end

  initial begin
    logic [31:0] d;
    logic flag_m, ien_m;
    logic [1:0] ptx, prx;
    void'($urandom(32'd20240611));

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, d); check("R1 ctrl", d, 32'h0000_8000);
    rd(2'd1, d); check("R1 ien", d, 32'h0);
    rd(2'd2, d); check("R1 stat", d, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);

    // R11 counters
    eng_rx_errcnt = 8'h5A; eng_tx_errcnt = 8'hC3;
    rd(2'd3, d); check("R11 ecnt", d, exp_ecnt(8'h5A, 8'hC3));

    // R4 / R5: timing write outside configuration mode ignored
    wr(2'd0, 32'h5A5A_3000);
    rd(2'd0, d); check("R4 ignored outside cfg", d, 32'h0000_8000);
    check("R12 timing idle", {16'h0, cfg_triple, cfg_tseg2, cfg_tseg1, cfg_sjw, cfg_brp}, 32'h0);

    // R2 entry handshake latency
    wr(2'd0, 32'h0000_0001);
    for (int k = 0; k <= LAT; k++) begin
      if (k > 0) @(negedge clk);
      rd(2'd0, d);
      check("R2 enter ack", {31'b0, d[8]}, {31'b0, k >= LAT});
    end
    check("R12 cfg_init", {31'b0, cfg_init}, 32'h1);

    // R4 accepted inside configuration mode; R12 outputs
    wr(2'd0, 32'h5A5A_3001);
    rd(2'd0, d); check("R4 accepted in cfg", d, 32'h5A5A_B101);
    check("R12 timing out", {16'h0, cfg_triple, cfg_tseg2, cfg_tseg1, cfg_sjw, cfg_brp}, 32'h5A5A);
    check("R12 listen/loop", {30'b0, cfg_loopback, cfg_listen}, 32'h3);

    // R10 / R7 / R6: state change while in configuration mode
    eng_tx_state = 2'd2;
    @(negedge clk);
    rd(2'd2, d); check("R7 flag on tx change", d, exp_stat(1'b1, 2'd0, 2'd2));
    wr(2'd0, 32'h5A5A_3001);
    rd(2'd2, d); check("R10 cfg keeps state and flag", d, exp_stat(1'b1, 2'd0, 2'd2));

    // R2 exit; the exit write lands while ack is still 1
    wr(2'd0, 32'h0000_0000);
    rd(2'd0, d); check("R4 write with ack high", d, 32'h0000_8100);
    for (int k = 1; k <= LAT; k++) begin
      @(negedge clk);
      rd(2'd0, d);
      check("R2 exit ack", {31'b0, d[8]}, {31'b0, k < LAT});
    end
    wr(2'd0, 32'hFFFF_3000);
    rd(2'd0, d); check("R4 ignored after exit", d, 32'h0000_8000);

    // R3 sleep handshake
    wr(2'd0, 32'h0000_0002);
    for (int k = 0; k <= LAT; k++) begin
      if (k > 0) @(negedge clk);
      rd(2'd0, d);
      check("R3 sleep ack", {31'b0, d[9]}, {31'b0, k >= LAT});
    end
    check("R12 cfg_sleep", {31'b0, cfg_sleep}, 32'h1);
    wr(2'd0, 32'h0);
    repeat (LAT) @(negedge clk);

    // R8 clear behaviour
    wr(2'd2, 32'h0);
    rd(2'd2, d); check("R8 write zero keeps flag", d, exp_stat(1'b1, 2'd0, 2'd2));
    wr(2'd2, 32'h0040_0000);
    rd(2'd2, d); check("R8 clear", d, exp_stat(1'b0, 2'd0, 2'd2));

    // R9 enable gating
    eng_rx_state = 2'd3;
    @(negedge clk);
    check("R9 irq masked", {31'b0, irq}, 32'h0);
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, d); check("R9 ien readback", d, 32'h40);
    check("R9 irq on", {31'b0, irq}, 32'h1);

    // R8 set wins over a coincident clear
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 32'h0040_0000; eng_tx_state = 2'd1;
    @(negedge clk);
    reg_wr = 1'b0;
    rd(2'd2, d); check("R8 set wins", d, exp_stat(1'b1, 2'd3, 2'd1));

    // Random phase: R6 R7 R8 R9 R11
    wr(2'd2, 32'h0040_0000);
    flag_m = 1'b0; ien_m = 1'b1;
    ptx = eng_tx_state; prx = eng_rx_state;
    for (int i = 0; i < 400; i++) begin
      logic w1c, clrbit;
      logic [1:0] ntx, nrx;
      @(negedge clk);
      ntx = ($urandom % 2) ? 2'($urandom) : ptx;
      nrx = ($urandom % 3 == 0) ? 2'($urandom) : prx;
      w1c = ($urandom % 4 == 0);
      clrbit = ($urandom % 2 == 0);
      eng_tx_state = ntx; eng_rx_state = nrx;
      eng_rx_errcnt = 8'($urandom); eng_tx_errcnt = 8'($urandom);
      reg_wr = w1c; reg_addr = 2'd2; reg_wdata = clrbit ? 32'h0040_0000 : 32'h0;
      if ((ntx != ptx) || (nrx != prx)) flag_m = 1'b1;
      else if (w1c && clrbit)          flag_m = 1'b0;
      ptx = ntx; prx = nrx;
      @(negedge clk);
      reg_wr = 1'b0;
      rd(2'd2, d); check("R7/R8 random stat", d, exp_stat(flag_m, nrx, ntx));
      check("R9 random irq", {31'b0, irq}, {31'b0, flag_m & ien_m});
      if (i % 8 == 0) begin
        rd(2'd3, d); check("R11 random ecnt", d, exp_ecnt(eng_rx_errcnt, eng_tx_errcnt));
      end
      if (i == 200) begin
        wr(2'd1, 32'h0);
        ien_m = 1'b0;
      end
    end

    done = 1;
    summary();
  end
endmodule